// File: doc/BRIEF.md
# Buffered Block-Program Controller

This block is the device-side engine of a fast factory programming mode for a NOR-style flash array model. A host on a simple word bus opens the mode with a two-write sequence: a setup code, then a confirm code whose address names the first word of a 32-word window inside one block. The controller then spends a fixed number of cycles checking the block's protection bit and the programming-voltage-good flag. A failure ends the mode and leaves the reason in a status byte.

When the checks pass, the host streams words to the same first-word address. Every such write is buffer data. Command codes are not decoded in this phase. Once 32 words are collected, the buffer is committed to the internal array over a fixed, parameterised latency. The internal write pointer then moves on by 32 words and wraps inside the block. A write to any other address ends streaming. In every phase except idle, reads return the status byte. In idle, reads return array contents.

Top module: `bfp_ctrl`

## Requirements
- R1: A write whose low byte is 0x80 in idle, followed by a write whose low byte is 0xD0, starts the checks. Status bit 7 (ready) reads 0 for SETUP_CYC cycles. Any other second write returns the block to idle.
- R2: If the lock input of the addressed block is high when the checks end, the mode stops and status reads 0x92 (bit 7 ready, bit 4 error, bit 1 lock).
- R3: If the voltage-good input is low when the checks end, the mode stops and status reads 0x98 (bit 7, bit 4, bit 3 voltage). When the block is also locked, status reads 0x9A.
- R4: With the read strobe high, rdata is {8'h00, status} in every state except idle, and the array word at addr in idle. With the read strobe low, rdata is 0.
- R5: During streaming, a write to the first-word address is stored as data whatever its value, including 0x70 and 0xFF.
- R6: The first-word address is the confirm address with bits [4:0] cleared.
- R7: The array changes only when a full 32-word buffer is committed. A partly filled buffer is dropped when streaming ends.
- R8: Each commit writes the 32 words in order from the current block offset. The offset then advances by 32 and wraps to the start of the same block.
- R9: Status reads 0x01 (bit 0, buffer free) while words are accepted. It reads 0x00 for exactly COMMIT_CYC cycles after the 32nd word, and the block then accepts words again.
- R10: Writes during the checks and during a commit, including the suspend code 0xB0, have no effect.
- R11: During streaming, a write to any address other than the first-word address ends the mode, and status reads 0x80.
- R12: After the mode ends, only a write whose low byte is 0xFF returns the block to idle. Other writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; the array resets to all ones |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address; the upper ADDR_W-BLK_OFF_W bits select the block |
| wdata | input | DATA_W | Write data; commands use bits [7:0] |
| rdata | output | DATA_W | Read data (status or array word) |
| lock_in | input | 2**(ADDR_W-BLK_OFF_W) | Protection bit for each block |
| vpp_ok | input | 1 | Programming voltage good |

## Verification
The streaming path is driven with a first window at offset 32 of block 0 and a second window that wraps to offset 0. Their words contain the read-status, suspend and read-array codes, so a design that decodes commands during streaming shows up at once. A third window is left partial and then ended by a stray address. The array scan that follows tells a design that drops a partial buffer from one that writes it. The setup checks are run with lock only, low voltage only, and both at once, so each status bit is tested on its own. A suspend write during a commit, a write during the checks, and a non-0xFF write after the mode ends each look for state that should not change.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_CHECK  = 3'd2,
        ST_STREAM = 3'd3,
        ST_COMMIT = 3'd4,
        ST_HALT   = 3'd5
    } bfp_state_e;

    localparam logic [7:0] OP_SETUP      = 8'h80;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;

    localparam int SB_READY = 7;
    localparam int SB_ERR   = 4;
    localparam int SB_VOLT  = 3;
    localparam int SB_LOCK  = 1;
    localparam int SB_FREE  = 0;
endpackage

// File: rtl/bfp_wordbuf.sv
module bfp_wordbuf #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              wr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [IDX_W-1:0]                  idx,
    output logic [(1<<IDX_W)*DATA_W-1:0]      words
);
    localparam int WORDS = 1 << IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0]        idx;
        logic [WORDS*DATA_W-1:0] words;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d.idx = '0;
        end else if (wr) begin
            b_d.words[b_q.idx*DATA_W +: DATA_W] = wdata;
            b_d.idx = b_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign idx   = b_q.idx;
    assign words = b_q.words;
endmodule

// File: rtl/bfp_array.sv
module bfp_array #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8,
    parameter int BLK_OFF_W = 6,
    parameter int BUF_W     = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [ADDR_W-BLK_OFF_W-1:0]        blk,
    input  logic [BLK_OFF_W-1:0]               base,
    input  logic [(1<<BUF_W)*DATA_W-1:0]       words,
    input  logic [ADDR_W-1:0]                  raddr,
    output logic [DATA_W-1:0]                  rdata
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BUF_WORDS = 1 << BUF_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < BUF_WORDS; i++)
                mem[{blk, BLK_OFF_W'(base + BLK_OFF_W'(i))}] <= words[i*DATA_W +: DATA_W];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bfp_ctrl.sv
module bfp_ctrl #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int BLK_OFF_W  = 6,
    parameter int BUF_W      = 5,
    parameter int SETUP_CYC  = 4,
    parameter int COMMIT_CYC = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic                                 rd_en,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [DATA_W-1:0]                    rdata,
    input  logic [(1<<(ADDR_W-BLK_OFF_W))-1:0]   lock_in,
    input  logic                                 vpp_ok
);
    import bfp_pkg::*;

    localparam int BLK_W     = ADDR_W - BLK_OFF_W;
    localparam int BUF_WORDS = 1 << BUF_W;
    localparam int MAX_CYC   = (SETUP_CYC > COMMIT_CYC) ? SETUP_CYC : COMMIT_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        bfp_state_e           st;
        logic [ADDR_W-1:0]    wa0;
        logic [BLK_OFF_W-1:0] ptr;
        logic [CNT_W-1:0]     cnt;
        logic [7:0]           sr;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic                        buf_clr, buf_wr, commit;
    logic [BUF_W-1:0]            buf_idx;
    logic [BUF_WORDS*DATA_W-1:0] buf_words;
    logic [DATA_W-1:0]           arr_rdata;
    logic [BLK_W-1:0]            blk_q;

    bfp_state_e           st_q;
    logic [7:0]           sr_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_W-1:0]    wa0_q;

    assign blk_q = r_q.wa0[ADDR_W-1:BLK_OFF_W];

    always_comb begin
        r_d     = r_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (wr_en && wdata[7:0] == OP_SETUP) begin
                    r_d.st  = ST_ARMED;
                    r_d.wa0 = addr;
                end
            end
            ST_ARMED: begin
                if (wr_en) begin
                    if (wdata[7:0] == OP_CONFIRM) begin
                        r_d.st  = ST_CHECK;
                        r_d.wa0 = {addr[ADDR_W-1:BUF_W], {BUF_W{1'b0}}};
                        r_d.ptr = {addr[BLK_OFF_W-1:BUF_W], {BUF_W{1'b0}}};
                        r_d.cnt = CNT_W'(SETUP_CYC - 1);
                        r_d.sr  = '0;
                        buf_clr = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_CHECK: begin
                if (r_q.cnt == '0) begin
                    if (lock_in[blk_q] || !vpp_ok) begin
                        r_d.st           = ST_HALT;
                        r_d.sr           = '0;
                        r_d.sr[SB_READY] = 1'b1;
                        r_d.sr[SB_ERR]   = 1'b1;
                        r_d.sr[SB_LOCK]  = lock_in[blk_q];
                        r_d.sr[SB_VOLT]  = !vpp_ok;
                    end else begin
                        r_d.st          = ST_STREAM;
                        r_d.sr          = '0;
                        r_d.sr[SB_FREE] = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_STREAM: begin
                if (wr_en) begin
                    if (addr == r_q.wa0) begin
                        buf_wr = 1'b1;
                        if (buf_idx == BUF_W'(BUF_WORDS - 1)) begin
                            r_d.st  = ST_COMMIT;
                            r_d.cnt = CNT_W'(COMMIT_CYC - 1);
                            r_d.sr  = '0;
                        end
                    end else begin
                        r_d.st           = ST_HALT;
                        r_d.sr           = '0;
                        r_d.sr[SB_READY] = 1'b1;
                        buf_clr          = 1'b1;
                    end
                end
            end
            ST_COMMIT: begin
                if (r_q.cnt == '0) begin
                    commit          = 1'b1;
                    r_d.ptr         = r_q.ptr + BLK_OFF_W'(BUF_WORDS);
                    r_d.st          = ST_STREAM;
                    r_d.sr          = '0;
                    r_d.sr[SB_FREE] = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HALT: begin
                if (wr_en && wdata[7:0] == OP_READ_ARRAY) begin
                    r_d.st = ST_IDLE;
                    r_d.sr = 8'h80;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.sr  <= 8'h80;
        end else begin
            r_q <= r_d;
        end
    end

    bfp_wordbuf #(.DATA_W(DATA_W), .IDX_W(BUF_W)) i_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .wr    (buf_wr),
        .wdata (wdata),
        .idx   (buf_idx),
        .words (buf_words)
    );

    bfp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .BUF_W(BUF_W)) i_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .blk    (blk_q),
        .base   (r_q.ptr),
        .words  (buf_words),
        .raddr  (addr),
        .rdata  (arr_rdata)
    );

    assign st_q  = r_q.st;
    assign sr_q  = r_q.sr;
    assign cnt_q = r_q.cnt;
    assign wa0_q = r_q.wa0;

    always_comb begin
        if (!rd_en)               rdata = '0;
        else if (st_q == ST_IDLE) rdata = arr_rdata;
        else                      rdata = {{(DATA_W-8){1'b0}}, sr_q};
    end
endmodule

// File: rtl/bfp_ctrl_chk.sv
module bfp_ctrl_chk #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int BLK_OFF_W  = 6,
    parameter int CNT_W      = 4,
    parameter int COMMIT_CYC = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               wr_en,
    input logic                               rd_en,
    input logic [ADDR_W-1:0]                  addr,
    input logic [DATA_W-1:0]                  wdata,
    input logic [DATA_W-1:0]                  rdata,
    input logic [(1<<(ADDR_W-BLK_OFF_W))-1:0] lock_in,
    input logic                               vpp_ok,
    input bfp_pkg::bfp_state_e                st_q,
    input logic [7:0]                         sr_q,
    input logic [CNT_W-1:0]                   cnt_q,
    input logic [ADDR_W-1:0]                  wa0_q
);
    import bfp_pkg::*;

    logic [15:0] commit_age;
    logic        lock_hit;

    assign lock_hit = lock_in[wa0_q[ADDR_W-1:BLK_OFF_W]];

    always_ff @(posedge clk) begin
        if (!rst_n)                 commit_age <= '0;
        else if (st_q == ST_COMMIT) commit_age <= commit_age + 1'b1;
        else                        commit_age <= '0;
    end

    // R1
    p_busy_in_check_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHECK) |-> !sr_q[7]);

    // R2
    p_lock_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHECK && cnt_q == '0 && lock_hit) |=> (st_q == ST_HALT && sr_q[4] && sr_q[1] && sr_q[7]));

    // R3
    p_volt_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHECK && cnt_q == '0 && !vpp_ok) |=> (st_q == ST_HALT && sr_q[4] && sr_q[3]));

    // R4
    p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st_q != ST_IDLE) |-> (rdata == {{(DATA_W-8){1'b0}}, sr_q}));

    // R5
    p_no_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STREAM && wr_en && addr == wa0_q && wdata[7:0] == 8'h70)
        |=> (st_q == ST_STREAM || st_q == ST_COMMIT));

    // R9
    p_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMMIT) |-> (sr_q == 8'h00));

    // R9
    p_commit_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMMIT && commit_age == 16'(COMMIT_CYC - 1)) |=> (st_q == ST_STREAM && sr_q == 8'h01));

    // R10
    p_commit_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMMIT && commit_age < 16'(COMMIT_CYC - 1)) |=> (st_q == ST_COMMIT));

    // R11
    p_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STREAM && wr_en && addr != wa0_q) |=> (st_q == ST_HALT && sr_q == 8'h80));

    // R12
    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !(wr_en && wdata[7:0] == 8'hFF)) |=> (st_q == ST_HALT && $stable(sr_q)));
endmodule

bind bfp_ctrl bfp_ctrl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .CNT_W(CNT_W), .COMMIT_CYC(COMMIT_CYC)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lock_in(lock_in), .vpp_ok(vpp_ok), .st_q(st_q), .sr_q(sr_q),
    .cnt_q(cnt_q), .wa0_q(wa0_q)
);

// File: tb/test_bfp_ctrl.sv
module test_bfp_ctrl;
    localparam int SETUP_CYC  = 4;
    localparam int COMMIT_CYC = 8;
    localparam int BUF_WORDS  = 32;
    localparam int BLK_WORDS  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  lock_in = '0;
    logic        vpp_ok = 1'b1;

    always #5 clk = ~clk;

    bfp_ctrl #(.SETUP_CYC(SETUP_CYC), .COMMIT_CYC(COMMIT_CYC)) i_bfp_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lock_in(lock_in), .vpp_ok(vpp_ok)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R4";

    // behavioural reference model
    int          m_st;
    logic [7:0]  m_sr;
    int          m_wa0, m_ptr, m_cnt;
    logic [15:0] m_mem [256];
    logic [15:0] m_q [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sr = 8'h80; m_q.delete();
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
        end else begin
            case (m_st)
                0: if (wr_en && wdata[7:0] == 8'h80) m_st = 1;
                1: if (wr_en) begin
                    if (wdata[7:0] == 8'hD0) begin
                        m_wa0 = int'(addr) & 32'hE0;
                        m_ptr = m_wa0 % BLK_WORDS;
                        m_cnt = SETUP_CYC; m_sr = 8'h00; m_q.delete(); m_st = 2;
                    end else m_st = 0;
                end
                2: begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (lock_in[m_wa0 / BLK_WORDS] || !vpp_ok) begin
                            m_sr = 8'h90 | (lock_in[m_wa0 / BLK_WORDS] ? 8'h02 : 8'h00) | (!vpp_ok ? 8'h08 : 8'h00);
                            m_st = 5;
                        end else begin
                            m_sr = 8'h01; m_st = 3;
                        end
                    end
                end
                3: if (wr_en) begin
                    if (int'(addr) == m_wa0) begin
                        m_q.push_back(wdata);
                        if (m_q.size() == BUF_WORDS) begin m_st = 4; m_cnt = COMMIT_CYC; m_sr = 8'h00; end
                    end else begin
                        m_st = 5; m_sr = 8'h80; m_q.delete();
                    end
                end
                4: begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        for (int i = 0; i < BUF_WORDS; i++)
                            m_mem[(m_wa0 / BLK_WORDS) * BLK_WORDS + (m_ptr + i) % BLK_WORDS] = m_q[i];
                        m_q.delete();
                        m_ptr = (m_ptr + BUF_WORDS) % BLK_WORDS;
                        m_sr = 8'h01; m_st = 3;
                    end
                end
                5: if (wr_en && wdata[7:0] == 8'hFF) begin m_st = 0; m_sr = 8'h80; end
                default: m_st = 0;
            endcase
        end
    end

    function automatic logic [15:0] expected_rdata();
        if (!rd_en)      return 16'h0000;
        if (m_st == 0)   return m_mem[addr];
        return {8'h00, m_sr};
    endfunction

    task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata actual %h expected %h (cycle %0d)", t, act, exp, cycles);
        end
    endtask

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) check(tag, rdata, expected_rdata());
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual cycles %0d expected below 50000", cycles);
            report();
        end
    end

    task automatic cyc(input logic w, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d;
    endtask

    task automatic idle_cycles(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 16'h0000);
    endtask

    task automatic open_mode(input logic [7:0] a);
        cyc(1'b1, a, 16'h0080);
        cyc(1'b1, a, 16'h00D0);
    endtask

    task automatic stream(input logic [7:0] a, input int n, input logic [15:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [15:0] v;
            v = seed + 16'(i);
            if (i == 3) v = 16'h0070;
            if (i == 5) v = 16'h00B0;
            if (i == 7) v = 16'h00FF;
            cyc(1'b1, a, v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R4 reset array", rdata, 16'hFFFF);

        // R1: setup followed by a non-confirm returns to idle
        tag = "R1";
        cyc(1'b1, 8'h10, 16'h0080);
        cyc(1'b1, 8'h10, 16'h0011);
        idle_cycles(2, 8'h10);

        // R6: confirm address 0x25 aligns to 0x20; R1 busy while checking; R10 write during checks
        tag = "R1";
        open_mode(8'h25);
        cyc(1'b1, 8'h20, 16'h1234);
        idle_cycles(SETUP_CYC, 8'h20);
        #2; check("R1 stream ready", rdata, 16'h0001);

        // R5/R6: first window, data includes command codes
        tag = "R5";
        stream(8'h20, BUF_WORDS, 16'h1000);
        // R9/R10: suspend code during commit is ignored
        tag = "R10";
        cyc(1'b1, 8'h20, 16'h00B0);
        #2; check("R9 commit busy", rdata, 16'h0000);
        tag = "R9";
        idle_cycles(COMMIT_CYC + 1, 8'h20);
        #2; check("R9 free again", rdata, 16'h0001);

        // R8: second window wraps to block offset 0
        tag = "R8";
        stream(8'h20, BUF_WORDS, 16'hA500);
        idle_cycles(COMMIT_CYC + 2, 8'h20);

        // R7: partial window then R11 stray address ends streaming
        tag = "R7";
        stream(8'h20, 10, 16'h5A00);
        tag = "R11";
        cyc(1'b1, 8'h00, 16'h4444);
        cyc(1'b0, 8'h00, 16'h0000);
        #2; check("R11 exit status", rdata, 16'h0080);

        // R12: non-0xFF writes after exit are ignored
        tag = "R12";
        cyc(1'b1, 8'h00, 16'h0080);
        cyc(1'b1, 8'h00, 16'h00D0);
        cyc(1'b0, 8'h00, 16'h0000);
        #2; check("R12 still halted", rdata, 16'h0080);
        cyc(1'b1, 8'h00, 16'h00FF);

        // R4: read strobe low gives zero
        tag = "R4";
        rd_en = 1'b0;
        cyc(1'b0, 8'h20, 16'h0000);
        rd_en = 1'b1;

        // R7/R8: scan the whole array
        tag = "R8";
        for (int a = 0; a < 256; a++) cyc(1'b0, 8'(a), 16'h0000);

        // R2: locked block 1
        tag = "R2";
        lock_in = 4'b0010;
        open_mode(8'h40);
        idle_cycles(SETUP_CYC + 1, 8'h40);
        #2; check("R2 lock status", rdata, 16'h0092);
        cyc(1'b1, 8'h40, 16'h00FF);

        // R3: low voltage on block 2, then on locked block 1
        tag = "R3";
        vpp_ok = 1'b0;
        open_mode(8'h80);
        idle_cycles(SETUP_CYC + 1, 8'h80);
        #2; check("R3 volt status", rdata, 16'h0098);
        cyc(1'b1, 8'h80, 16'h00FF);
        open_mode(8'h60);
        idle_cycles(SETUP_CYC + 1, 8'h60);
        #2; check("R3 both status", rdata, 16'h009A);
        cyc(1'b1, 8'h60, 16'h00FF);
        vpp_ok = 1'b1;
        lock_in = '0;

        // R7: array unchanged by failed modes
        tag = "R7";
        for (int a = 64; a < 192; a += 16) cyc(1'b0, 8'(a), 16'h0000);
        idle_cycles(2, 8'h00);
        report();
    end
endmodule